// File: doc/BRIEF.md
# SDRAM Clock Gating and Self-Refresh Controller

This block drives three memory clock outputs, three clock-enable outputs and three command buses. One set serves a synchronous ROM region and the other two serve a pair of SDRAM bank pairs each. Software controls it through one 32-bit control word. The word holds a run enable for each clock, two automatic power-down enables (one for the clocks, one for the clock-enable pins), an exit length, and a self-refresh control bit that also reads back as status.

Each clock output passes through a glitch-free gate. When automatic clock power-down is on, a clock runs only while its bank group reports activity. Setting the self-refresh bit makes each SDRAM group send a self-refresh entry command and then hold its clock-enable low. Clearing the bit starts an exit sequence. The exit goes ahead only when that group's run bit is 1 and both power-down enables are 0. The exit raises clock-enable, sends a programmable number of NOP cycles, and then marks the group ready for traffic.

A hardware reset or a sleep-reset strobe puts the control word back in its start state, with self-refresh set. The ROM run bit and the ROM clock-enable bit take the level of a boot-strap pin at that time.

Top module: `memclk_sr_ctrl`

## Requirements
- R1: After a hardware reset or a sleep-reset pulse, the control word reads 0x8000_0000, plus 0x800 for the default exit length of 8, plus 0x9 when the boot pin is 1. So the self-refresh bit is 1, both power-down enables are 0 and the SDRAM run bits are 0. The ROM run bit (bit 0) and the ROM clock-enable bit (bit 3) both equal the boot pin.
- R2: A write loads the fields as follows: self-refresh at bit 31, clock power-down enable at bit 29, clock-enable-pin power-down enable at bit 28, exit length at bits 15:8, ROM clock-enable at bit 3, and run bits at 2:0 (bit g for clock g). A read returns these fields. Bit 30 always reads 0. Bit 27 reads the exit-blocked status and cannot be written.
- R3: Clock g pulses in a cycle only if the gate is forced (R6), or if its run bit is 1 and either the clock power-down enable is 0 or activity input g was high during the preceding low clock phase.
- R4: `apd_mismatch` is 1 exactly when the two power-down enables hold different values.
- R5: Setting self-refresh while an SDRAM group is in normal operation makes that group drive the entry command {cs_n,ras_n,cas_n,we_n}=4'b0001. This happens two cycles after the write, on the same cycle that its clock-enable goes low, and lasts one cycle. After that the group drives NOP (4'b0111) with clock-enable low.
- R6: During the entry command cycle and every exit cycle, the group's clock runs regardless of its run bit and the power-down enables.
- R7: When self-refresh is cleared and the exit is allowed, the group holds clock-enable high and drives NOP for N cycles, starting two cycles after the write. N is the exit length field, and a value of 0 counts as 1. `grp_ready[g]` then goes high.
- R8: While self-refresh is 0 but a group's run bit is 0 or either power-down enable is 1, that group stays in self-refresh with clock-enable low, and `exit_blocked` is 1.
- R9: The ROM group always drives NOP and is always ready. Its clock-enable is ROM clock-enable AND (NOT pin power-down enable OR activity 0).
- R10: In normal operation an SDRAM group's clock-enable is NOT pin power-down enable OR its activity input.
- R11: A sleep-reset pulse does not reset the sequencers. A group that was in normal operation therefore sends the entry command (R5) two cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sleep_rst | input | 1 | Synchronous sleep-reset strobe (control word only) |
| boot_rom_en | input | 1 | Boot-strap pin sampled into the ROM run and clock-enable bits on reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data with status |
| grp_active | input | 3 | Per-group access activity (0 ROM, 1 pair 0/1, 2 pair 2/3) |
| mem_clk | output | 3 | Gated memory clocks |
| mem_cke | output | 3 | Per-group clock-enable |
| mem_cmd | output | 12 | Per-group command, group g at [4g+3:4g] as {cs_n,ras_n,cas_n,we_n} |
| grp_ready | output | 3 | Group open for normal commands |
| apd_mismatch | output | 1 | Power-down enables disagree |
| exit_blocked | output | 1 | A requested self-refresh exit is being held off |

## Verification
The bench targets the cycle in which the entry command is sent. It checks that cs_n, ras_n and cas_n are low together with clock-enable low, and that the gated clock runs even though the run bit was just cleared; a design that sampled the command one cycle late or left the clock gated would put the entry outside any clock edge. It checks the exit NOP window for both a nonzero length and a zero length, so an off-by-one counter or a zero-length wrap would release the bus early or hang. It covers exits held off by a cleared run bit and by the power-down enables, where a faulty design would drive clock-enable high on an SDRAM with no clock. It also covers a sleep reset with the boot pin low, which must re-enter self-refresh and drop the ROM clock.

// File: rtl/memclk_pkg.sv
`timescale 1ns/1ps
package memclk_pkg;

    localparam int NUM_CLK    = 3;
    localparam int ROM_CLK    = 0;
    localparam int NOP_W      = 8;
    localparam int REG_W      = 32;

    localparam int BIT_SR     = 31;
    localparam int BIT_RSVD   = 30;
    localparam int BIT_CAPD   = 29;
    localparam int BIT_EAPD   = 28;
    localparam int BIT_BLK    = 27;
    localparam int NOP_LSB    = 8;
    localparam int BIT_ROMCKE = 3;
    localparam int RUN_LSB    = 0;

    typedef enum logic [1:0] {
        ST_NORMAL,
        ST_ENTER,
        ST_HOLD,
        ST_EXIT
    } sr_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } mem_cmd_t;

    localparam int CMD_W = $bits(mem_cmd_t);

    typedef struct packed {
        logic               self_refresh;
        logic               clk_apd;
        logic               cke_apd;
        logic               rom_cke;
        logic [NUM_CLK-1:0] run;
        logic [NOP_W-1:0]   nop_len;
    } ctrl_t;

    function automatic mem_cmd_t cmd_nop();
        mem_cmd_t c;
        c.cs_n = 1'b0; c.ras_n = 1'b1; c.cas_n = 1'b1; c.we_n = 1'b1;
        return c;
    endfunction

    function automatic mem_cmd_t cmd_sre();
        mem_cmd_t c;
        c.cs_n = 1'b0; c.ras_n = 1'b0; c.cas_n = 1'b0; c.we_n = 1'b1;
        return c;
    endfunction

    // A zero length still gives one NOP cycle.
    function automatic logic [NOP_W-1:0] exit_len(input logic [NOP_W-1:0] n);
        return (n == '0) ? NOP_W'(1) : n;
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [REG_W-1:0] d);
        ctrl_t c;
        c.self_refresh = d[BIT_SR];
        c.clk_apd      = d[BIT_CAPD];
        c.cke_apd      = d[BIT_EAPD];
        c.rom_cke      = d[BIT_ROMCKE];
        c.run          = d[RUN_LSB +: NUM_CLK];
        c.nop_len      = d[NOP_LSB +: NOP_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_encode(input ctrl_t c, input logic blk);
        logic [REG_W-1:0] r;
        r                    = '0;
        r[BIT_SR]            = c.self_refresh;
        r[BIT_CAPD]          = c.clk_apd;
        r[BIT_EAPD]          = c.cke_apd;
        r[BIT_BLK]           = blk;
        r[BIT_ROMCKE]        = c.rom_cke;
        r[RUN_LSB +: NUM_CLK] = c.run;
        r[NOP_LSB +: NOP_W]  = c.nop_len;
        return r;
    endfunction

endpackage

// File: rtl/memclk_gate.sv
`timescale 1ns/1ps
module memclk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    // Enable is captured while the clock is low, so it cannot change
    // during a high phase and no shortened pulse can appear.
    logic en_q;

    always_latch begin
        if (!clk) en_q <= en;
    end

    assign gclk = clk & en_q;
endmodule

// File: rtl/memclk_regs.sv
`timescale 1ns/1ps
module memclk_regs
    import memclk_pkg::*;
#(
    parameter int unsigned DEF_NOP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_rst,
    input  logic             boot_pin,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             blocked,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] rd_data
);
    ctrl_t q;

    function automatic ctrl_t start_val(input logic boot);
        ctrl_t c;
        c.self_refresh = 1'b1;
        c.clk_apd      = 1'b0;
        c.cke_apd      = 1'b0;
        c.rom_cke      = boot;
        c.run          = '0;
        c.run[ROM_CLK] = boot;
        c.nop_len      = NOP_W'(DEF_NOP);
        return c;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || sleep_rst) q <= start_val(boot_pin);
        else if (wr_en)       q <= ctrl_decode(wr_data);
    end

    assign ctrl    = q;
    assign rd_data = ctrl_encode(q, blocked);

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[BIT_RSVD], wr_data[BIT_BLK],
                              wr_data[26:NOP_LSB+NOP_W], wr_data[NOP_LSB-1:BIT_ROMCKE+1]};

    AST_RESET_SETS_SR: assert property (@(posedge clk) disable iff (rst)
        $past(rst || sleep_rst) |-> q.self_refresh)
        else $error("self-refresh not set after reset"); // R1

    AST_BOOT_COPY: assert property (@(posedge clk) disable iff (rst)
        $past(rst || sleep_rst) |-> (q.run[ROM_CLK] == $past(boot_pin)
                                     && q.rom_cke == $past(boot_pin)))
        else $error("boot pin not copied"); // R1

    AST_WRITE_APD: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && !rst && !sleep_rst) |->
            (q.clk_apd == $past(wr_data[BIT_CAPD]) && q.cke_apd == $past(wr_data[BIT_EAPD])))
        else $error("power-down enables not loaded"); // R2
endmodule

// File: rtl/memclk_sr_seq.sv
`timescale 1ns/1ps
module memclk_sr_seq
    import memclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sr_req,
    input  logic             run_en,
    input  logic             clk_apd,
    input  logic             cke_apd,
    input  logic             grp_busy,
    input  logic [NOP_W-1:0] nop_len,
    output logic             cke,
    output mem_cmd_t         cmd,
    output logic             force_clk,
    output logic             ready,
    output logic             blocked
);
    sr_state_e        st, st_nx;
    logic [NOP_W-1:0] cnt, cnt_nx;
    logic             exit_ok;

    assign exit_ok = run_en & ~clk_apd & ~cke_apd;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_NORMAL: if (sr_req) st_nx = ST_ENTER;
            ST_ENTER:  st_nx = ST_HOLD;
            ST_HOLD: begin
                if (!sr_req && exit_ok) begin
                    st_nx  = ST_EXIT;
                    cnt_nx = exit_len(nop_len);
                end
            end
            ST_EXIT: begin
                if (cnt <= NOP_W'(1)) st_nx = ST_NORMAL;
                else                  cnt_nx = cnt - NOP_W'(1);
            end
            default: st_nx = ST_HOLD;
        endcase
    end

    // Memories are assumed to be in self-refresh after a hardware reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_HOLD;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // Command and clock-enable both decode from the state register and
    // therefore change on the same edge.
    always_comb begin
        cke       = 1'b0;
        cmd       = cmd_nop();
        force_clk = 1'b0;
        ready     = 1'b0;
        unique case (st)
            ST_NORMAL: begin
                cke   = ~cke_apd | grp_busy;
                ready = 1'b1;
            end
            ST_ENTER: begin
                cmd       = cmd_sre();
                force_clk = 1'b1;
            end
            ST_EXIT: begin
                cke       = 1'b1;
                force_clk = 1'b1;
            end
            default: ;
        endcase
    end

    assign blocked = (st == ST_HOLD) & ~sr_req & ~exit_ok;

    AST_ENTRY_CMD: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NORMAL && sr_req) |=> (cmd == cmd_sre() && !cke && force_clk))
        else $error("entry command missing"); // R5

    AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ENTER) |=> (cmd == cmd_nop() && !cke))
        else $error("entry command not single cycle"); // R5

    AST_HOLD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !exit_ok) |=> !cke)
        else $error("exit started while not allowed"); // R8

    AST_EXIT_START: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !sr_req && exit_ok) |=> (cke && cmd == cmd_nop() && force_clk && !ready))
        else $error("exit sequence malformed"); // R7
endmodule

// File: rtl/memclk_sr_ctrl.sv
`timescale 1ns/1ps
module memclk_sr_ctrl
    import memclk_pkg::*;
#(
    parameter int unsigned DEF_NOP = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sleep_rst,
    input  logic                     boot_rom_en,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_data,
    output logic [REG_W-1:0]         rd_data,
    input  logic [NUM_CLK-1:0]       grp_active,
    output logic [NUM_CLK-1:0]       mem_clk,
    output logic [NUM_CLK-1:0]       mem_cke,
    output logic [NUM_CLK*CMD_W-1:0] mem_cmd,
    output logic [NUM_CLK-1:0]       grp_ready,
    output logic                     apd_mismatch,
    output logic                     exit_blocked
);
    ctrl_t              ctrl;
    logic [NUM_CLK-1:0] grp_cke, grp_force, grp_rdy, grp_blk, gate_en;
    mem_cmd_t           grp_cmd [NUM_CLK];

    memclk_regs #(.DEF_NOP(DEF_NOP)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .sleep_rst(sleep_rst),
        .boot_pin (boot_rom_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .blocked  (exit_blocked),
        .ctrl     (ctrl),
        .rd_data  (rd_data)
    );

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_grp
        if (g == ROM_CLK) begin : g_rom
            assign grp_cke[g]   = ctrl.rom_cke & (~ctrl.cke_apd | grp_active[g]);
            assign grp_cmd[g]   = cmd_nop();
            assign grp_force[g] = 1'b0;
            assign grp_rdy[g]   = 1'b1;
            assign grp_blk[g]   = 1'b0;
        end else begin : g_sdram
            memclk_sr_seq u_seq (
                .clk      (clk),
                .rst      (rst),
                .sr_req   (ctrl.self_refresh),
                .run_en   (ctrl.run[g]),
                .clk_apd  (ctrl.clk_apd),
                .cke_apd  (ctrl.cke_apd),
                .grp_busy (grp_active[g]),
                .nop_len  (ctrl.nop_len),
                .cke      (grp_cke[g]),
                .cmd      (grp_cmd[g]),
                .force_clk(grp_force[g]),
                .ready    (grp_rdy[g]),
                .blocked  (grp_blk[g])
            );
        end

        assign gate_en[g] = grp_force[g] | (ctrl.run[g] & (~ctrl.clk_apd | grp_active[g]));

        memclk_gate u_gate (
            .clk (clk),
            .en  (gate_en[g]),
            .gclk(mem_clk[g])
        );

        assign mem_cmd[g*CMD_W +: CMD_W] = grp_cmd[g];
    end

    assign mem_cke      = grp_cke;
    assign grp_ready    = grp_rdy;
    assign exit_blocked = |grp_blk;
    assign apd_mismatch = ctrl.clk_apd ^ ctrl.cke_apd;

    AST_MISMATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && !rst && !sleep_rst) |->
            (apd_mismatch == ($past(wr_data[BIT_CAPD]) != $past(wr_data[BIT_EAPD]))))
        else $error("mismatch flag wrong"); // R4
endmodule

// File: tb/memclk_sr_ctrl_test.sv
`timescale 1ns/1ps
module memclk_sr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_rst = 1'b0;
    logic        boot_rom_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  grp_active = '0;
    logic [2:0]  mem_clk, mem_cke, grp_ready;
    logic [11:0] mem_cmd;
    logic        apd_mismatch, exit_blocked;

    memclk_sr_ctrl uut (.*);

    always #2.5 clk = ~clk;

    localparam int P_RD = 0, P_CLK = 1, P_CKE = 2, P_CMD = 3, P_RDY = 4, P_MIS = 5, P_BLK = 6;
    localparam logic [11:0] CMD_IDLE = 12'h777; // every group NOP 4'b0111
    localparam logic [11:0] CMD_SRE2 = 12'h117; // both SDRAM groups 4'b0001

    typedef struct {
        int          cyc;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;

    always @(posedge clk) cyc++;

    function automatic logic [31:0] probe(int sel);
        case (sel)
            P_RD:    return rd_data;
            P_CLK:   return {29'd0, mem_clk};
            P_CKE:   return {29'd0, mem_cke};
            P_CMD:   return {20'd0, mem_cmd};
            P_RDY:   return {29'd0, grp_ready};
            P_MIS:   return {31'd0, apd_mismatch};
            default: return {31'd0, exit_blocked};
        endcase
    endfunction

    // Monitor: half-way through the high phase, compare every item due now.
    always @(posedge clk) begin
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                logic [31:0] act;
                act = probe(sb[i].sel);
                checks++;
                if (act !== sb[i].exp) begin
                    fails++;
                    $display("FAIL %s probe=%0d cycle=%0d actual=%h expected=%h",
                             sb[i].req, sb[i].sel, cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic e(int off, int sel, logic [31:0] exp, string req);
        item_t it;
        it.cyc = cyc + off; it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        step(3);
        // Reset state, boot pin high
        e(1, P_RD,  32'h8000_0809, "R1");
        e(1, P_CKE, 32'h1, "R1 R9");
        e(1, P_CMD, CMD_IDLE, "R1 R9");
        e(1, P_RDY, 32'h1, "R1");
        e(1, P_MIS, 32'h0, "R1");
        e(1, P_BLK, 32'h0, "R1");
        e(2, P_CLK, 32'h1, "R3");
        rst = 1'b0;
        step(3);

        // Exit pair 0/1 only, length 3; pair 2/3 blocked by run bit
        e(1, P_RD,  32'h0800_030B, "R2 R8");
        e(1, P_BLK, 32'h1, "R8");
        e(2, P_CKE, 32'h3, "R7");
        e(2, P_CMD, CMD_IDLE, "R7");
        e(3, P_CLK, 32'h3, "R6");
        e(4, P_RDY, 32'h1, "R7");
        e(5, P_RDY, 32'h3, "R7");
        e(5, P_CKE, 32'h3, "R8");
        wr(32'h0000_030B);
        step(6);

        // Release pair 2/3
        e(1, P_BLK, 32'h0, "R8");
        e(1, P_RD,  32'h0000_030F, "R2");
        e(2, P_CKE, 32'h7, "R7");
        e(4, P_RDY, 32'h3, "R7");
        e(5, P_RDY, 32'h7, "R7");
        wr(32'h0000_030F);
        step(6);

        // Both power-down enables on: clocks follow activity
        e(1, P_RD,  32'h3000_030F, "R2");
        e(1, P_CKE, 32'h0, "R9 R10");
        e(1, P_MIS, 32'h0, "R4");
        e(2, P_CLK, 32'h0, "R3");
        wr(32'h3000_030F);
        step(2);
        grp_active = 3'b010;
        e(1, P_CLK, 32'h2, "R3");
        e(1, P_CKE, 32'h2, "R10");
        step(1);
        grp_active = 3'b101;
        e(1, P_CLK, 32'h5, "R3");
        e(1, P_CKE, 32'h5, "R9 R10");
        e(1, P_RDY, 32'h7, "R10");
        step(1);
        grp_active = 3'b000;
        e(1, P_CLK, 32'h0, "R3");
        step(2);

        // Mismatched enables; reserved bit 30 written as 1
        e(1, P_MIS, 32'h1, "R4");
        e(1, P_RD,  32'h2000_030F, "R2");
        e(2, P_CLK, 32'h0, "R3");
        wr(32'h6000_030F);
        step(2);
        e(1, P_MIS, 32'h0, "R4");
        e(1, P_CKE, 32'h7, "R10");
        e(2, P_CLK, 32'h7, "R3");
        wr(32'h0000_030F);
        step(3);

        // Self-refresh entry with SDRAM run bits cleared
        e(1, P_RD,  32'h8000_0309, "R2");
        e(1, P_CMD, CMD_IDLE, "R5");
        e(1, P_CKE, 32'h7, "R5");
        e(2, P_CLK, 32'h1, "R3");
        e(2, P_CMD, CMD_SRE2, "R5");
        e(2, P_CKE, 32'h1, "R5");
        e(2, P_RDY, 32'h1, "R5");
        e(3, P_CLK, 32'h7, "R6");
        e(3, P_CMD, CMD_IDLE, "R5");
        e(3, P_CKE, 32'h1, "R5");
        e(4, P_CLK, 32'h1, "R6");
        wr(32'h8000_0309);
        step(5);

        // Exit requested but power-down enables on; length 0
        e(1, P_RD,  32'h3800_000F, "R8");
        e(1, P_BLK, 32'h1, "R8");
        e(3, P_CKE, 32'h0, "R8");
        e(4, P_RDY, 32'h1, "R8");
        wr(32'h3000_000F);
        step(5);
        e(1, P_BLK, 32'h0, "R8");
        e(1, P_RD,  32'h0000_000F, "R2");
        e(2, P_CKE, 32'h7, "R7");
        e(2, P_RDY, 32'h1, "R7");
        e(2, P_CMD, CMD_IDLE, "R7");
        e(3, P_CLK, 32'h7, "R6");
        e(3, P_RDY, 32'h7, "R7");
        wr(32'h0000_000F);
        step(5);

        // Sleep reset with boot pin low
        boot_rom_en = 1'b0;
        e(1, P_RD,  32'h8000_0800, "R11 R1");
        e(1, P_MIS, 32'h0, "R11");
        e(2, P_CMD, CMD_SRE2, "R11");
        e(2, P_CKE, 32'h0, "R11");
        e(2, P_RDY, 32'h1, "R11");
        e(3, P_CLK, 32'h6, "R11 R6");
        e(3, P_CMD, CMD_IDLE, "R11");
        sleep_rst = 1'b1;
        step(1);
        sleep_rst = 1'b0;
        step(5);

        if (sb.size() != 0) begin
            checks += sb.size();
            fails  += sb.size();
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule